// File: doc/BRIEF.md
# Guarded Watchdog Timer

This block is a watchdog counter that software must keep servicing. It counts pulses on a tick input. When the selected number of ticks passes without a clear, it raises a single-cycle expiry pulse and starts again from zero. The pulse can feed a system reset controller or an interrupt line. Two byte-wide registers share one write port. The master register holds the enable request, the period selection and the halt-mode field, and it only accepts a byte that carries a fixed key in its low bits. The command register takes code bytes that clear the count, disable the counter, or unlock the next halt-mode change. Every other code written to it is dropped.

The timeout is a power of two. The base exponent and the step between the four selectable periods are parameters. The default values give 2^16, 2^18, 2^20 and 2^22 ticks. Turning the watchdog off takes two separate actions: the enable bit must first be written as 0 in the master register, and then the disable code must be written. The current halt mode is driven on an output for the power controller. This block only reports the mode and does not act on it.

Register writes are plain strobes with no back-pressure: `cfg_wr` is sampled on every rising clock edge, and each write is always accepted or dropped in that same cycle. A write takes effect from the next clock cycle onward. The exception is a clear, which also applies to a tick that arrives in the same cycle as the clear.

Top module: `wdog_guard`

## Requirements
- R1: After reset, the watchdog is enabled, the period selection is 0 (2^BASE_EXP ticks), `halt_mode` is 2'b11 (run), and `expire` is low.
- R2: While the watchdog is enabled, the N-th counted tick since the count was last zero raises `expire` for exactly one cycle, in the cycle after that tick, where N is the selected period. The count then restarts from zero.
- R3: A master write (`cfg_sel`=0) sets the period from data bits [6:5], value p, to 2^(BASE_EXP+PER_STEP*p) ticks.
- R4: A master write whose data bits [2:0] are not 3'b011 is ignored completely: the enable, the period and the halt mode all stay unchanged.
- R5: Writing 8'h4E to the command register (`cfg_sel`=1) sets the count to zero. A tick in the same cycle is not counted.
- R6: Writing 8'h B1 to the command register, when the last accepted master write had bit 7 equal to 0, disables the watchdog. While it is disabled, the count is held at zero and `expire` stays low.
- R7: Writing 8'hB1 while the last accepted master bit 7 is 1 has no effect. A master write with bit 7 = 0 does not stop the counter on its own.
- R8: `halt_mode` (00 idle1, 01 idle2, 10 stop, 11 run) takes data bits [4:3] only on the first accepted master write after a command write of 8'hDB. Any other master write leaves `halt_mode` unchanged.
- R9: Command bytes other than 8'h4E, 8'hB1 and 8'hDB have no effect on the count, the enable or the halt mode.
- R10: An accepted master write with bit 7 = 1 enables the watchdog, and counting restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects the master register, 1 selects the command register |
| cfg_data | input | 8 | Write data |
| tick | input | 1 | One count step per cycle while high |
| expire | output | 1 | Single-cycle timeout pulse |
| halt_mode | output | 2 | Current halt-mode field |

## Verification
The bench builds the block with BASE_EXP=4 and PER_STEP=2. This gives periods of 16, 64, 256 and 1024 ticks. With these values the bench can run through every period selection, reach wrap-around at the longest period, and check that a disabled counter stays silent, all in a few thousand cycles. With the default exponents a single timeout would take millions of cycles. The counter width and the per-period terminal values come from the same parameters, so the reduced build uses the same structure as the default.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam logic [7:0] CODE_KICK   = 8'h4E;
  localparam logic [7:0] CODE_OFF    = 8'hB1;
  localparam logic [7:0] CODE_UNLOCK = 8'hDB;
  localparam logic [2:0] MASTER_KEY  = 3'b011;

  typedef enum logic [1:0] {
    HM_IDLE1 = 2'b00,
    HM_IDLE2 = 2'b01,
    HM_STOP  = 2'b10,
    HM_RUN   = 2'b11
  } halt_t;

  typedef struct packed {
    logic       en_req;
    logic [1:0] per;
    logic [1:0] halt;
    logic [2:0] key;
  } master_t;

endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic       cfg_sel,
  input  logic [7:0] cfg_data,
  output logic       run_en,
  output logic [1:0] per_sel,
  output halt_t      halt_q,
  output logic       clr_cnt
);

  master_t mw;
  logic    mst_ok;
  logic    cmd_wr;
  logic    off_hit;
  logic    unlock_hit;
  logic    en_req_q;
  logic    unlock_q;

  assign mw         = master_t'(cfg_data);
  assign mst_ok     = cfg_wr && !cfg_sel && (mw.key == MASTER_KEY);
  assign cmd_wr     = cfg_wr && cfg_sel;
  assign clr_cnt    = cmd_wr && (cfg_data == CODE_KICK);
  assign off_hit    = cmd_wr && (cfg_data == CODE_OFF);
  assign unlock_hit = cmd_wr && (cfg_data == CODE_UNLOCK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_req_q <= 1'b1;
      run_en   <= 1'b1;
      per_sel  <= 2'b00;
      halt_q   <= HM_RUN;
      unlock_q <= 1'b0;
    end else begin
      if (mst_ok) begin
        en_req_q <= mw.en_req;
        per_sel  <= mw.per;
        if (unlock_q) halt_q <= halt_t'(mw.halt);
      end
      if (mst_ok && mw.en_req)            run_en <= 1'b1;
      else if (off_hit && !en_req_q)      run_en <= 1'b0;
      if (unlock_hit)                     unlock_q <= 1'b1;
      else if (mst_ok)                    unlock_q <= 1'b0;
    end
  end

  assert_halt_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q != $past(halt_q)) |-> $past(mst_ok && unlock_q));

  assert_reject_bad_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_sel && cfg_data[2:0] != MASTER_KEY)
      |=> ($stable(per_sel) && $stable(halt_q)));

  assert_off_needs_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_en) |-> $past(cfg_wr && cfg_sel && cfg_data == CODE_OFF));

  assert_on_needs_master_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_en) |-> $past(cfg_wr && !cfg_sel && cfg_data[7]));

endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int unsigned BASE_EXP = 16,
  parameter int unsigned PER_STEP = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_en,
  input  logic [1:0] per_sel,
  input  logic       clr_cnt,
  input  logic       tick,
  output logic       expire
);

  localparam int unsigned NPER = 4;
  localparam int unsigned CW   = BASE_EXP + PER_STEP * (NPER - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_val [NPER];
  logic          at_end;

  for (genvar g = 0; g < NPER; g++) begin : g_term
    localparam int unsigned EXP = BASE_EXP + PER_STEP * g;
    assign last_val[g] = CW'((64'd1 << EXP) - 64'd1);
  end

  assign at_end = (cnt_q >= last_val[per_sel]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      expire <= 1'b0;
    end else begin
      expire <= run_en && tick && !clr_cnt && at_end;
      if (!run_en || clr_cnt)  cnt_q <= '0;
      else if (tick)           cnt_q <= at_end ? '0 : cnt_q + 1'b1;
    end
  end

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);

  assert_pulse_from_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> $past(tick && run_en));

  assert_silent_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !expire);

  assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cnt |=> (cnt_q == '0 && !expire));

endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
  import wdog_pkg::*;
#(
  parameter int unsigned BASE_EXP = 16,
  parameter int unsigned PER_STEP = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic       cfg_sel,
  input  logic [7:0] cfg_data,
  input  logic       tick,
  output logic       expire,
  output logic [1:0] halt_mode
);

  logic       run_en;
  logic [1:0] per_sel;
  logic       clr_cnt;
  halt_t      halt_q;

  wdog_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .cfg_sel  (cfg_sel),
    .cfg_data (cfg_data),
    .run_en   (run_en),
    .per_sel  (per_sel),
    .halt_q   (halt_q),
    .clr_cnt  (clr_cnt)
  );

  wdog_count #(
    .BASE_EXP (BASE_EXP),
    .PER_STEP (PER_STEP)
  ) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_en  (run_en),
    .per_sel (per_sel),
    .clr_cnt (clr_cnt),
    .tick    (tick),
    .expire  (expire)
  );

  assign halt_mode = halt_q;

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (!expire && halt_mode == 2'b11));

endmodule

// File: tb/wdog_guard_test.sv
`timescale 1ns/1ps
module wdog_guard_test;

  localparam int unsigned B = 4;
  localparam int unsigned S = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic       cfg_sel = 1'b0;
  logic [7:0] cfg_data = 8'h00;
  logic       tick = 1'b0;
  logic       expire;
  logic [1:0] halt_mode;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // reference model state
  int unsigned m_cnt;
  bit          m_act, m_men, m_unl, m_exp;
  logic [1:0]  m_psel, m_halt;

  wdog_guard #(.BASE_EXP(B), .PER_STEP(S)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .tick(tick), .expire(expire), .halt_mode(halt_mode)
  );

  always #4 clk = ~clk;

  function automatic int unsigned period_of(logic [1:0] p);
    return 32'd1 << (B + S * p);
  endfunction

  function automatic void model_reset();
    m_cnt = 0; m_act = 1; m_men = 1; m_unl = 0; m_exp = 0;
    m_psel = 2'b00; m_halt = 2'b11;
  endfunction

  function automatic void model_step(bit w, bit sel, logic [7:0] d, bit t);
    bit clr, mv, last;
    clr  = w && sel && d == 8'h4E;
    mv   = w && !sel && d[2:0] == 3'b011;
    last = m_cnt >= period_of(m_psel) - 1;
    m_exp = m_act && t && !clr && last;
    if (!m_act || clr) m_cnt = 0;
    else if (t) m_cnt = last ? 0 : m_cnt + 1;
    if (mv && d[7]) m_act = 1;
    else if (w && sel && d == 8'hB1 && !m_men) m_act = 0;
    if (mv) begin
      m_men = d[7];
      m_psel = d[6:5];
      if (m_unl) m_halt = d[4:3];
    end
    if (w && sel && d == 8'hDB) m_unl = 1;
    else if (mv) m_unl = 0;
  endfunction

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, update model, compare after the edge
  task automatic cyc(string req, bit w, bit sel, logic [7:0] d, bit t);
    cfg_wr = w; cfg_sel = sel; cfg_data = d; tick = t;
    model_step(w, sel, d, t);
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 0; tick = 0;
    check(req, "expire", {7'd0, expire}, {7'd0, m_exp});
    check(req, "halt_mode", {6'd0, halt_mode}, {6'd0, m_halt});
  endtask

  task automatic ticks(string req, int n);
    for (int i = 0; i < n; i++) cyc(req, 0, 0, 8'h00, 1);
  endtask

  task automatic expect_pulse_after(string req, int n);
    int seen = 0;
    for (int i = 1; i <= n; i++) begin
      cyc(req, 0, 0, 8'h00, 1);
      if (expire) seen = i;
    end
    check(req, "pulse tick index", seen[7:0], n[7:0]);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check("R1", "expire after reset", {7'd0, expire}, 8'd0);
    check("R1", "halt after reset", {6'd0, halt_mode}, 8'd3);
    expect_pulse_after("R1", 16);           // R2 base period
    expect_pulse_after("R2", 16);           // restarts from zero
    // R3 / R8: period 1 (64), halt not unlocked so stays run
    cyc("R8", 1, 0, 8'hA3, 0);
    check("R8", "halt locked", {6'd0, halt_mode}, 8'd3);
    expect_pulse_after("R3", 64);
    // R4: bad key tries period 0 and halt change
    cyc("R4", 1, 1, 8'hDB, 0);
    cyc("R4", 1, 0, 8'h8C, 0);
    check("R4", "halt kept", {6'd0, halt_mode}, 8'd3);
    expect_pulse_after("R4", 64);
    // R5: clear mid-count, and clear with a tick in the same cycle
    ticks("R5", 30);
    cyc("R5", 1, 1, 8'h4E, 1);
    expect_pulse_after("R5", 64);
    // R9: unknown codes ignored
    ticks("R9", 10);
    cyc("R9", 1, 1, 8'h55, 1);
    cyc("R9", 1, 1, 8'h00, 0);
    cyc("R9", 1, 1, 8'hB2, 0);
    expect_pulse_after("R9", 53);
    // R7: B1 with enable bit set is ignored; bit7=0 alone keeps running
    cyc("R7", 1, 1, 8'hB1, 0);
    cyc("R7", 1, 0, 8'h03, 0);
    check("R8", "halt after unlocked write", {6'd0, halt_mode}, 8'd0);
    expect_pulse_after("R7", 16);
    // R6: disable, no pulses over many ticks
    cyc("R6", 1, 1, 8'hB1, 0);
    begin
      int seen = 0;
      for (int i = 0; i < 1500; i++) begin
        cyc("R6", 0, 0, 8'h00, 1);
        if (expire) seen++;
      end
      check("R6", "pulses while off", seen[7:0], 8'd0);
    end
    // R10: re-enable, counting from zero
    cyc("R10", 1, 0, 8'h83, 0);
    expect_pulse_after("R10", 16);
    // R8: unlock then halt 01, second write cannot change it
    cyc("R8", 1, 1, 8'hDB, 0);
    cyc("R8", 1, 0, 8'h8B, 0);
    check("R8", "halt idle2", {6'd0, halt_mode}, 8'd1);
    cyc("R8", 1, 0, 8'h93, 0);
    check("R8", "halt one-shot", {6'd0, halt_mode}, 8'd1);
    // R3 longest period wraps
    cyc("R3", 1, 0, 8'hE3, 0);
    ticks("R3", 1023);
    cyc("R3", 0, 0, 8'h00, 1);
    check("R3", "pulse at 1024", {7'd0, expire}, 8'd1);
    cyc("R3", 1, 0, 8'h83, 0);
    // randomized phase, checked against the model every cycle
    for (int i = 0; i < 20000; i++) begin
      bit w, t;
      logic [7:0] d;
      bit sel;
      int unsigned r;
      w = ($urandom % 30) == 0;
      t = $urandom % 2;
      sel = 0;
      d = 8'h00;
      if (w) begin
        r = $urandom % 9;
        case (r)
          0: begin sel = 1; d = 8'h4E; end
          1: begin sel = 1; d = 8'hB1; end
          2: begin sel = 1; d = 8'hDB; end
          3: begin sel = 1; d = 8'($urandom); end
          4: begin d = {1'b0, 2'($urandom % 2), 2'($urandom), 3'b011}; end
          5: begin d = 8'($urandom); end
          default: begin d = {1'b1, 2'($urandom % 2), 2'($urandom), 3'b011}; end
        endcase
      end
      cyc("R2", w, sel, d, t);
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule